// File: doc/BRIEF.md
# Scheduler Event Sequence Classifier

This block sits beside a processor that runs a preemptive real-time kernel. It watches the address bus and compares the address against a small programmable table of kernel routine entry points on every clock cycle. Five kinds of routine are known: semaphore lock, semaphore unlock, interrupt entry, IO request and reschedule. Only entry addresses are visible. The block never sees routine arguments, so it cannot tell which semaphore or which device a call refers to.

The block infers why the kernel is about to switch tasks from the order in which these routines are entered. A prefix routine arms a pending cause. The next reschedule entry turns that pending cause into a one-cycle event strobe that carries a 3-bit cause code. No timer tick input is needed: an interrupt entry followed by a reschedule entry is classified as a tick. A downstream task-list monitor uses the strobe and code to keep its ready and blocked lists in step with the kernel.

Top module: `sesc_classifier`

## Requirements
- R1: After reset, `evt_strobe` is 0 and `evt_code` is 0, and every table entry is invalid, so no bus address can produce an event.
- R2: When `cfg_we` is high at a clock edge, the entry at `cfg_idx` takes `cfg_addr`, `cfg_kind` and `cfg_valid`, and it takes part in matching from the next cycle on. The kind encoding is 0 lock, 1 unlock, 2 interrupt, 3 IO request and 4 reschedule. An entry with kind 5 to 7, or with its valid bit at 0, never matches.
- R3: A routine kind counts as entered only in the first cycle of a run of consecutive cycles in which that kind matches. Holding an address for several cycles gives one entry, while a gap of one non-matching cycle makes the next match a new entry.
- R4: A lock entry followed by a reschedule entry gives code 2 (semaphore block).
- R5: An interrupt entry followed by a reschedule entry gives code 1 (tick).
- R6: An unlock entry followed by a reschedule entry gives code 3 (semaphore release). An IO request entry followed by a reschedule entry gives code 4 (IO block).
- R7: The sequence interrupt, IO request, reschedule gives code 5 (IO completion signalled by interrupt).
- R8: A reschedule entry with no pending prefix gives code 6 (unknown cause). Codes 0 and 7 never appear with the strobe.
- R9: A new prefix entry replaces any pending cause. The only exception is an IO request that follows a pending interrupt, which extends that interrupt to the R7 sequence. Every reschedule entry clears the pending cause.
- R10: The strobe is high for exactly one cycle. It rises on the clock edge that samples the reschedule address, and `evt_code` is 0 whenever the strobe is low.
- R11: If several kinds are entered in the same cycle, only one counts. The priority is reschedule, then interrupt, then IO request, then lock, then unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Observed bus address |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_addr | input | ADDR_W | Entry address to store |
| cfg_kind | input | 3 | Routine kind of the entry |
| cfg_valid | input | 1 | Entry valid bit |
| evt_strobe | output | 1 | One-cycle scheduler event pulse |
| evt_code | output | 3 | Event cause code, 0 when idle |

## Verification
A wrong pending cause is invisible until the next reschedule entry arrives. At that point it shows up at the ports as a wrong code on the strobe, one clock edge after the reschedule address is presented. A fault in the repeat collapsing shows up as a doubled strobe or as a lost prefix when addresses are held for several cycles. A fault in the table shows up as events from invalid or unprogrammed entries. The bench compares strobe and code in every cycle against a sequence model, so any such fault is seen within one cycle of the reschedule entry that exposes it.

// File: rtl/sesc_pkg.sv
package sesc_pkg;
   localparam int NUM_FN = 5;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      FN_LOCK    = 3'd0,
      FN_UNLOCK  = 3'd1,
      FN_IRQ     = 3'd2,
      FN_IO      = 3'd3,
      FN_RESCHED = 3'd4
   } fn_kind_e;

   typedef enum logic [2:0] {
      EV_NONE        = 3'd0,
      EV_TICK        = 3'd1,
      EV_SEM_BLOCK   = 3'd2,
      EV_SEM_RELEASE = 3'd3,
      EV_IO_BLOCK    = 3'd4,
      EV_IO_DONE     = 3'd5,
      EV_UNKNOWN     = 3'd6
   } evt_e;

   typedef enum logic [2:0] {
      PD_IDLE   = 3'd0,
      PD_LOCK   = 3'd1,
      PD_UNLOCK = 3'd2,
      PD_IRQ    = 3'd3,
      PD_IO     = 3'd4,
      PD_IRQ_IO = 3'd5
   } pend_e;
endpackage

// File: rtl/sesc_addr_table.sv
module sesc_addr_table
   import sesc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [KIND_W-1:0] wr_kind,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [NUM_FN-1:0] kind_hit
);
   logic [ADDR_W-1:0] ent_addr  [ENTRIES];
   logic [KIND_W-1:0] ent_kind  [ENTRIES];
   logic [ENTRIES-1:0] ent_valid;
   logic [ENTRIES-1:0] ent_match;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[e] <= 1'b0;
            ent_addr[e]  <= '0;
            ent_kind[e]  <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            ent_valid[e] <= wr_valid;
            ent_addr[e]  <= wr_addr;
            ent_kind[e]  <= wr_kind;
         end
      end
      assign ent_match[e] = ent_valid[e] && (ent_addr[e] == probe_addr);
   end

   for (genvar k = 0; k < NUM_FN; k++) begin : g_kind
      logic [ENTRIES-1:0] sel;
      for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
         assign sel[e] = ent_match[e] && (ent_kind[e] == KIND_W'(k));
      end
      assign kind_hit[k] = |sel;
   end
endmodule

// File: rtl/sesc_entry_edge.sv
module sesc_entry_edge #(
   parameter int WIDTH    = 5,
   parameter bit COLLAPSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit,
   output logic [WIDTH-1:0] entry
);
   if (COLLAPSE) begin : g_collapse
      logic [WIDTH-1:0] hit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hit_q <= '0;
         else        hit_q <= hit;
      end
      assign entry = hit & ~hit_q;
   end else begin : g_raw
      assign entry = hit;
   end
endmodule

// File: rtl/sesc_seq_fsm.sv
module sesc_seq_fsm
   import sesc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_FN-1:0] entry,
   output logic              strobe,
   output logic [2:0]        code
);
   pend_e    pend_q, pend_d;
   logic     strobe_d;
   evt_e     code_d;
   evt_e     code_q;
   logic     sel_any;
   fn_kind_e sel_kind;

   always_comb begin
      sel_any  = 1'b1;
      sel_kind = FN_RESCHED;
      if      (entry[FN_RESCHED]) sel_kind = FN_RESCHED;
      else if (entry[FN_IRQ])     sel_kind = FN_IRQ;
      else if (entry[FN_IO])      sel_kind = FN_IO;
      else if (entry[FN_LOCK])    sel_kind = FN_LOCK;
      else if (entry[FN_UNLOCK])  sel_kind = FN_UNLOCK;
      else                        sel_any  = 1'b0;
   end

   always_comb begin
      pend_d   = pend_q;
      strobe_d = 1'b0;
      code_d   = EV_NONE;
      if (sel_any) begin
         unique case (sel_kind)
            FN_RESCHED: begin
               strobe_d = 1'b1;
               pend_d   = PD_IDLE;
               unique case (pend_q)
                  PD_LOCK:   code_d = EV_SEM_BLOCK;
                  PD_UNLOCK: code_d = EV_SEM_RELEASE;
                  PD_IRQ:    code_d = EV_TICK;
                  PD_IO:     code_d = EV_IO_BLOCK;
                  PD_IRQ_IO: code_d = EV_IO_DONE;
                  default:   code_d = EV_UNKNOWN;
               endcase
            end
            FN_IRQ:    pend_d = PD_IRQ;
            FN_IO:     pend_d = (pend_q == PD_IRQ) ? PD_IRQ_IO : PD_IO;
            FN_LOCK:   pend_d = PD_LOCK;
            FN_UNLOCK: pend_d = PD_UNLOCK;
            default:   pend_d = pend_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= PD_IDLE;
         strobe <= 1'b0;
         code_q <= EV_NONE;
      end else begin
         pend_q <= pend_d;
         strobe <= strobe_d;
         code_q <= code_d;
      end
   end

   assign code = code_q;
endmodule

// File: rtl/sesc_classifier.sv
module sesc_classifier
   import sesc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int ENTRIES  = 8,
   parameter bit COLLAPSE = 1'b1,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [2:0]        cfg_kind,
   input  logic              cfg_valid,
   output logic              evt_strobe,
   output logic [2:0]        evt_code
);
   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $error("sesc_classifier: ENTRIES must lie in 2..256");
   end
   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr
      $error("sesc_classifier: ADDR_W must lie in 4..64");
   end

   logic [NUM_FN-1:0] fn_hit;
   logic [NUM_FN-1:0] fn_entry;

   sesc_addr_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_idx     (cfg_idx),
      .wr_addr    (cfg_addr),
      .wr_kind    (cfg_kind),
      .wr_valid   (cfg_valid),
      .probe_addr (bus_addr),
      .kind_hit   (fn_hit)
   );

   sesc_entry_edge #(.WIDTH(NUM_FN), .COLLAPSE(COLLAPSE)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (fn_hit),
      .entry (fn_entry)
   );

   sesc_seq_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .entry  (fn_entry),
      .strobe (evt_strobe),
      .code   (evt_code)
   );
endmodule

// File: rtl/sesc_classifier_chk.sv
module sesc_classifier_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       evt_strobe,
   input logic [2:0] evt_code,
   input logic       resched_hit
);
   // R10: no code while idle
   p_idle_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_strobe |-> evt_code == 3'd0);

   // R10: pulse lasts one cycle
   p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_strobe |=> !evt_strobe);

   // R10: a strobe follows a sampled reschedule match
   p_after_resched_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_strobe) |-> $past(resched_hit));

   // R8: strobe codes stay in 1..6
   p_code_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_strobe |-> (evt_code != 3'd0 && evt_code != 3'd7));
endmodule

bind sesc_classifier sesc_classifier_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_strobe  (evt_strobe),
   .evt_code    (evt_code),
   .resched_hit (fn_hit[sesc_pkg::FN_RESCHED])
);

// File: tb/sesc_classifier_test.sv
`timescale 1ns/1ps
module sesc_classifier_test;
   localparam int AW = 32;
   localparam int NE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_addr = '0;
   logic [2:0]    cfg_kind = '0;
   logic          cfg_valid = 1'b0;
   logic          evt_strobe;
   logic [2:0]    evt_code;

   sesc_classifier #(.ADDR_W(AW), .ENTRIES(NE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
      .cfg_kind(cfg_kind), .cfg_valid(cfg_valid),
      .evt_strobe(evt_strobe), .evt_code(evt_code)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R1";

   localparam logic [AW-1:0] A_LOCK = 32'h1000, A_UNL = 32'h1100, A_IRQ = 32'h1200,
                             A_IO = 32'h1300, A_RS = 32'h1400, A_INV = 32'h1500,
                             A_BADK = 32'h1600, A_LOCK2 = 32'h1010, A_IDLE = 32'h9000;

   // sequence model
   logic [AW-1:0] m_addr [NE];
   logic [2:0]    m_kind [NE];
   bit            m_val  [NE];
   bit [4:0]      m_prev;
   int            m_pend;   // 0 none 1 lock 2 unlock 3 irq 4 io 5 irq+io
   bit            x_strobe;
   int            x_code;

   task automatic model_step(input logic [AW-1:0] a);
      bit [4:0] hit = '0;
      bit [4:0] ent;
      int sel = -1;
      for (int e = 0; e < NE; e++)
         if (m_val[e] && m_kind[e] < 3'd5 && m_addr[e] == a) hit[m_kind[e]] = 1'b1;
      ent = hit & ~m_prev;
      m_prev = hit;
      if (ent[4]) sel = 4; else if (ent[2]) sel = 2; else if (ent[3]) sel = 3;
      else if (ent[0]) sel = 0; else if (ent[1]) sel = 1;
      x_strobe = 0; x_code = 0;
      case (sel)
         4: begin
            x_strobe = 1;
            case (m_pend) 1: x_code = 2; 2: x_code = 3; 3: x_code = 1;
                          4: x_code = 4; 5: x_code = 5; default: x_code = 6; endcase
            m_pend = 0;
         end
         2: m_pend = 3;
         3: m_pend = (m_pend == 3) ? 5 : 4;
         0: m_pend = 1;
         1: m_pend = 2;
         default: ;
      endcase
      if (cfg_we) begin
         m_addr[cfg_idx] = cfg_addr; m_kind[cfg_idx] = cfg_kind; m_val[cfg_idx] = cfg_valid;
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare after the sampling edge
   task automatic cyc(input logic [AW-1:0] a);
      bus_addr = a;
      model_step(a);
      @(negedge clk);
      check(cur_req, {evt_strobe, evt_code}, {x_strobe, 3'(x_code)});
   endtask

   task automatic prog(input int idx, input logic [AW-1:0] a, input int k, input bit v);
      cfg_we = 1; cfg_idx = 3'(idx); cfg_addr = a; cfg_kind = 3'(k); cfg_valid = v;
      cyc(A_IDLE);
      cfg_we = 0;
   endtask

   task automatic expect_evt(input string req, input int code);
      check(req, {evt_strobe, evt_code}, (code == 0) ? 0 : (8 | code));
   endtask

   initial begin
      for (int e = 0; e < NE; e++) begin m_addr[e] = '0; m_kind[e] = '0; m_val[e] = 0; end
      m_prev = '0; m_pend = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", {evt_strobe, evt_code}, 0);
      // R1: empty table, nothing matches
      cur_req = "R1";
      cyc(32'h0); cyc(A_RS); expect_evt("R1", 0);
      cur_req = "R2";
      prog(0, A_LOCK, 0, 1); prog(1, A_UNL, 1, 1); prog(2, A_IRQ, 2, 1);
      prog(3, A_IO, 3, 1);   prog(4, A_RS, 4, 1);  prog(5, A_INV, 4, 0);
      prog(6, A_BADK, 7, 1); prog(7, A_LOCK2, 0, 1);
      // R2: invalid entry and illegal kind never match
      cyc(A_INV); expect_evt("R2", 0); cyc(A_BADK); expect_evt("R2", 0); cyc(A_IDLE);
      cur_req = "R4"; cyc(A_LOCK); cyc(A_RS); expect_evt("R4", 2); cyc(A_IDLE);
      cur_req = "R5"; cyc(A_IRQ); cyc(A_IDLE); cyc(A_RS); expect_evt("R5", 1); cyc(A_IDLE);
      cur_req = "R6"; cyc(A_UNL); cyc(A_RS); expect_evt("R6", 3); cyc(A_IDLE);
      cyc(A_IO); cyc(A_RS); expect_evt("R6", 4); cyc(A_IDLE);
      cur_req = "R7"; cyc(A_IRQ); cyc(A_IO); cyc(A_RS); expect_evt("R7", 5); cyc(A_IDLE);
      cur_req = "R8"; cyc(A_RS); expect_evt("R8", 6); cyc(A_IDLE);
      cur_req = "R9"; cyc(A_LOCK); cyc(A_UNL); cyc(A_RS); expect_evt("R9", 3); cyc(A_IDLE);
      cyc(A_IRQ); cyc(A_LOCK2); cyc(A_RS); expect_evt("R9", 2); cyc(A_IDLE);
      cyc(A_RS); expect_evt("R9", 6); cyc(A_IDLE);
      // R3: held addresses collapse; lock then lock2 back-to-back is one lock run
      cur_req = "R3";
      cyc(A_LOCK); cyc(A_LOCK); cyc(A_LOCK2); cyc(A_RS); expect_evt("R3", 2);
      cyc(A_RS); expect_evt("R3", 0); cyc(A_RS); expect_evt("R3", 0);
      cyc(A_IDLE); cyc(A_RS); expect_evt("R3", 6);
      // R10: one-cycle pulse then idle code
      cur_req = "R10"; cyc(A_IDLE); expect_evt("R10", 0);
      // R11: irq and reschedule on one address, reschedule wins
      cur_req = "R11";
      prog(5, A_RS, 2, 1);
      cyc(A_UNL); cyc(A_RS); expect_evt("R11", 3); cyc(A_IDLE);
      cyc(A_RS); expect_evt("R11", 6); cyc(A_IDLE);
      // random traffic
      cur_req = "R3-random";
      void'($urandom(32'h5EED_0042));
      begin
         logic [AW-1:0] pool [8];
         logic [AW-1:0] a = A_IDLE;
         pool = '{A_LOCK, A_UNL, A_IRQ, A_IO, A_RS, A_LOCK2, A_BADK, A_IDLE};
         for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(9) > 2) a = pool[$urandom_range(7)];
            else if ($urandom_range(3) == 0) a = $urandom();
            cyc(a);
         end
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule